// File: doc/BRIEF.md
# Gated IF Counter with Lock Check

This block measures the frequency of an intermediate-frequency (IF) signal and checks whether a PLL holds lock. Both jobs are started by a control load carrying two bits: a count enable and a gate select. A measurement always begins with an 8-tick lock-check window. During that window a lock-error input from the phase comparator is sampled every clock, and any assertion of it sets a sticky unlock flag. When counting is enabled, the counting gate opens only after the lock check has ended. The gate lasts 16 or 32 ticks. During the gate, rising edges of the synchronized IF input are counted by a saturating counter.

A 1 kHz tick input provides the timebase, so one tick is 1 ms. When the work ends, the active-low done output falls. The count can then be read serially, least significant bit first. Each rising edge of the serial clock advances the readout by one bit. The next control load raises done again and starts over.

Top module: `gated_if_counter`

## Requirements
- R1: After reset, done_no is 1, sdata_o is 0 and unlock_o is 0, and the block is idle.
- R2: On the clock after load_i is sampled high, done_no is 1 and the count is cleared, including when done_no was low.
- R3: When the loaded count enable is 1, an 8-tick lock-check window runs first and the counting gate follows it. IF rising edges are counted only while the gate is open.
- R4: The loaded gate select chooses the gate length: 0 gives 16 ticks and 1 gives 32 ticks. Ticks are counted after the lock-check window.
- R5: With count enable 0 and gate select 1, only the 8-tick lock-check window runs, and the count read out afterwards is 0.
- R6: done_no goes low on the clock after the tick that ends the last window. The total is 24 ticks (enable 1, select 0), 40 ticks (enable 1, select 1) or 8 ticks (enable 0, select 1), counted from the load.
- R7: While done_no is low, sdata_o shows bit 0 of the count. Each rising edge of sclk_i shifts the count toward bit 0, with 0 filling the top. While done_no is high, sdata_o is 0.
- R8: unlock_o is set by any lock_err_i sample taken during the lock-check window. Samples taken outside that window have no effect. The flag stays set until a load with both bits 0 clears it.
- R9: The count saturates at all ones (2^CNT_W - 1) and does not wrap.
- R10: A load with both bits 0 leaves the block idle: done_no stays high and no window runs.
- R11: if_i passes through a two-flop synchronizer, and only its rising edges add to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 kHz timebase pulse, one clock wide |
| load_i | input | 1 | Control load strobe |
| ct_i | input | 1 | Count enable, captured on load |
| gt_i | input | 1 | Gate select, captured on load (0: 16 ticks, 1: 32 ticks) |
| if_i | input | 1 | Asynchronous IF input |
| lock_err_i | input | 1 | Lock-error pulse from the phase comparator |
| sclk_i | input | 1 | Serial readout clock, sampled by clk_i |
| done_no | output | 1 | Active-low done |
| sdata_o | output | 1 | Serial count output, least significant bit first |
| unlock_o | output | 1 | Sticky unlock flag |

## Verification
The assertions assume that tick_i, load_i, sclk_i and lock_err_i are already synchronous to clk_i, and that each sclk_i high and low phase lasts at least one clock. Only if_i is treated as asynchronous. The stimulus follows these assumptions: it changes every input on the falling clock edge, drives ticks as single-cycle pulses, holds each sclk_i phase and each IF pulse level for at least one full clock, and issues loads as single-cycle strobes. The saturation case runs with a narrow counter width so that the count overflows within one 32-tick gate.

// File: rtl/gic_pkg.sv
package gic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_UNLK,
    ST_GATE,
    ST_DONE
  } gic_state_e;
endpackage

// File: rtl/gic_edge_sync.sv
module gic_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], data_i};
  end

  // chain_q[STAGES] is the previous synchronized level
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/gic_window_timer.sv
module gic_window_timer #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/gic_sat_counter.sv
module gic_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         shift_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q_q <= '0;
    else if (clr_i)               q_q <= '0;
    else if (shift_i)             q_q <= {1'b0, q_q[W-1:1]};
    else if (inc_i && ~&q_q)      q_q <= q_q + 1'b1;
  end

  assign q_o = q_q;

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&q_q && inc_i && !clr_i && !shift_i) |=> &q_q);
endmodule

// File: rtl/gated_if_counter.sv
module gated_if_counter
  import gic_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int UNLK_TICKS = 8,
  parameter int GATE_SHORT = 16,
  parameter int GATE_LONG  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  logic ct_i,
  input  logic gt_i,
  input  logic if_i,
  input  logic lock_err_i,
  input  logic sclk_i,
  output logic done_no,
  output logic sdata_o,
  output logic unlock_o
);
  localparam int TW = $clog2(GATE_LONG + 1);
  localparam logic [TW-1:0] LIM_UNLK  = TW'(UNLK_TICKS);
  localparam logic [TW-1:0] LIM_SHORT = TW'(GATE_SHORT);
  localparam logic [TW-1:0] LIM_LONG  = TW'(GATE_LONG);

  gic_state_e     state_q;
  logic           ct_q, gt_q, done_n_q, unlock_q, sclk_q;
  logic           if_rise, win_exp, win_run;
  logic [TW-1:0]  win_lim;
  logic [CNT_W-1:0] cnt_q;

  gic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .data_i(if_i), .rise_o(if_rise)
  );

  assign win_run = !load_i && (state_q == ST_UNLK || state_q == ST_GATE);
  assign win_lim = (state_q == ST_UNLK) ? LIM_UNLK : (gt_q ? LIM_LONG : LIM_SHORT);

  gic_window_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .clr_i(load_i), .run_i(win_run), .tick_i,
    .limit_i(win_lim), .expire_o(win_exp)
  );

  // count register doubles as the readout shift register
  gic_sat_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i  (load_i),
    .inc_i  (state_q == ST_GATE && if_rise),
    .shift_i(state_q == ST_DONE && sclk_i && !sclk_q),
    .q_o    (cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ct_q     <= 1'b0;
      gt_q     <= 1'b0;
      done_n_q <= 1'b1;
      unlock_q <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (load_i) begin
        ct_q     <= ct_i;
        gt_q     <= gt_i;
        done_n_q <= 1'b1;
        if (!ct_i && !gt_i) unlock_q <= 1'b0;
        state_q  <= (ct_i || gt_i) ? ST_UNLK : ST_IDLE;
      end else begin
        unique case (state_q)
          ST_UNLK: begin
            if (lock_err_i) unlock_q <= 1'b1;
            if (win_exp) begin
              if (ct_q) state_q <= ST_GATE;
              else begin
                state_q  <= ST_DONE;
                done_n_q <= 1'b0;
              end
            end
          end
          ST_GATE: if (win_exp) begin
            state_q  <= ST_DONE;
            done_n_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign done_no  = done_n_q;
  assign sdata_o  = ~done_n_q & cnt_q[0];
  assign unlock_o = unlock_q;

  assert_done_high_after_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> done_no);
  assert_unlock_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !ct_i && !gt_i) |=> !unlock_o);
  assert_no_count_in_unlk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNLK) |-> (cnt_q == '0));
  assert_sdata_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_no |-> !sdata_o);
  assert_idle_stays_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !load_i) |=> (state_q == ST_IDLE && done_no));
endmodule

// File: tb/gated_if_counter_tb.sv
module gated_if_counter_tb;
  localparam int W    = 10;
  localparam int TP   = 100;
  localparam int MAXV = (1 << W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 0, load_i = 0, ct_i = 0, gt_i = 0, if_i = 0, lock_err_i = 0, sclk_i = 0;
  logic done_no, sdata_o, unlock_o;

  int checks = 0, fails = 0;
  int tick_ph = 0, ticks_since = 0;
  // reference model state
  int m_st = 0, m_tk = 0, m_cnt = 0;
  bit m_ct = 0, m_gt = 0, m_dn = 1, m_unl = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_sq = 0;

  always #5 clk_i = ~clk_i;

  gated_if_counter #(.CNT_W(W)) u_dut (
    .clk_i, .rst_ni, .tick_i, .load_i, .ct_i, .gt_i, .if_i, .lock_err_i,
    .sclk_i, .done_no, .sdata_o, .unlock_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit rise, sr;
    rise = m_s2 && !m_s3;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = if_i;
    sr = sclk_i && !m_sq; m_sq = sclk_i;
    if (load_i) begin
      m_ct = ct_i; m_gt = gt_i; m_dn = 1; m_tk = 0; m_cnt = 0;
      if (!ct_i && !gt_i) m_unl = 0;
      m_st = (ct_i || gt_i) ? 1 : 0;
    end else if (m_st == 1) begin
      if (lock_err_i) m_unl = 1;
      if (tick_i) begin
        if (m_tk == 7) begin
          m_tk = 0;
          if (m_ct) m_st = 2; else begin m_st = 3; m_dn = 0; end
        end else m_tk++;
      end
    end else if (m_st == 2) begin
      if (rise && m_cnt < MAXV) m_cnt++;
      if (tick_i) begin
        if (m_tk == (m_gt ? 31 : 15)) begin m_tk = 0; m_st = 3; m_dn = 0; end
        else m_tk++;
      end
    end else if (m_st == 3) begin
      if (sr) m_cnt = m_cnt >> 1;
    end
  endtask

  task automatic cyc();
    tick_i = (tick_ph == TP - 1);
    @(posedge clk_i);
    tick_ph = (tick_ph + 1) % TP;
    if (rst_ni) begin
      model_step();
      if (tick_i && !load_i) ticks_since++;
    end
    @(negedge clk_i);
    if (rst_ni) begin
      chk("model done_no", done_no, m_dn);
      chk("model sdata_o", sdata_o, m_dn ? 0 : (m_cnt & 1));
      chk("model unlock_o", unlock_o, m_unl);
    end
  endtask

  task automatic do_load(bit c, bit g);
    load_i = 1; ct_i = c; gt_i = g; ticks_since = 0;
    cyc();
    load_i = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      if_i = 1; cyc(); cyc();
      if_i = 0; cyc(); cyc();
    end
  endtask

  task automatic wait_ticks(int n);
    while (ticks_since < n) cyc();
  endtask

  task automatic wait_done();
    int g = 0;
    while (done_no && g < 20000) begin cyc(); g++; end
  endtask

  task automatic read_word(int nbits, output int v);
    v = 0;
    for (int i = 0; i < nbits; i++) begin
      v |= int'(sdata_o) << i;
      sclk_i = 1; cyc();
      sclk_i = 0; cyc();
    end
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    chk("R1 done_no reset", done_no, 1);
    chk("R1 sdata_o reset", sdata_o, 0);
    chk("R1 unlock_o reset", unlock_o, 0);
    rst_ni = 1;
    cyc(); cyc();

    // R10: idle load
    do_load(0, 0);
    chk("R2 done_no after load", done_no, 1);
    wait_ticks(10);
    chk("R10 idle keeps done high", done_no, 1);

    // R3/R4/R6/R11: enable=1 select=0, 37 pulses in gate, pulses in lock window ignored
    do_load(1, 0);
    pulses(5);
    wait_ticks(10);
    pulses(37);
    lock_err_i = 1; cyc(); lock_err_i = 0;
    wait_done();
    chk("R4 R6 ticks for short gate", ticks_since, 24);
    chk("R8 lock error outside window ignored", unlock_o, 0);
    read_word(W, v);
    chk("R3 R11 count short gate", v, 37);
    chk("R7 zero fill after readout", sdata_o, 0);

    // enable=1 select=1, lock error inside window
    do_load(1, 1);
    cyc(); cyc();
    lock_err_i = 1; cyc(); lock_err_i = 0;
    wait_ticks(9);
    pulses(100);
    wait_done();
    chk("R4 R6 ticks for long gate", ticks_since, 40);
    chk("R8 unlock set in window", unlock_o, 1);
    chk("R7 first bit is LSB", sdata_o, 0);
    read_word(W, v);
    chk("R3 count long gate", v, 100);

    // R5: lock check only
    do_load(0, 1);
    pulses(20);
    wait_done();
    chk("R5 R6 ticks lock check only", ticks_since, 8);
    chk("R8 unlock sticky", unlock_o, 1);
    read_word(W, v);
    chk("R5 count zero", v, 0);

    do_load(0, 0);
    chk("R8 unlock cleared", unlock_o, 0);

    // R9: saturation
    do_load(1, 1);
    while (done_no && ticks_since < 60) begin if_i = ~if_i; cyc(); end
    if_i = 0;
    chk("R9 saturated bit0", sdata_o, 1);
    read_word(3, v);
    chk("R9 saturated low bits", v, 7);

    // R2: load during readout
    do_load(0, 0);
    chk("R2 done high after load in readout", done_no, 1);
    chk("R2 sdata quiet after load", sdata_o, 0);
    cyc(); cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule